// File: doc/BRIEF.md
# Ethernet Receive Frame Admission Filter

This block watches the byte stream of received frames on its way from a MAC to a packet buffer and decides, once per frame, whether the frame is kept. It captures the destination address from the first six bytes and compares it against several sources. These are a programmed station address and the broadcast address. For group-addressed frames the sources are an accept-every-group mode and a 64-entry hash table, indexed by six bits that an external CRC unit supplies. A promiscuous mode covers everything else. A frame is also refused if the collision input aborts it, if it is too short, or if it is too long. An overlong frame sets a sticky status bit.

The decision arrives as a one-cycle pulse in the cycle after the last byte. The pulse carries the accept flag and the length the buffer should commit. When stripping is on, that length leaves out the four trailing CRC bytes, so the buffer never commits them. An 8-bit control register holds the mode bits and the sticky oversize flag.

The input is a valid/ready stream. The block takes a byte in every cycle where `s_valid` and `s_ready` are both high, and `s_last` marks the final byte of a frame. `s_ready` drops for exactly one cycle, the cycle in which the decision pulse is shown. It is high at all other times. The sender must hold its byte stable while `s_ready` is low.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset every control register bit reads 0, `dec_valid` is 0 and `s_ready` is 1.
- R2: In the cycle after the beat that carries `s_last`, `dec_valid` is high for exactly one cycle and `s_ready` is low in that same cycle. `dec_valid` is never high in two consecutive cycles.
- R3: The receive-enable bit (bit 0) is sampled on the first beat of a frame. A frame that starts while it is 0 produces no decision. Clearing the bit in the middle of a frame still lets that frame complete and receive its decision.
- R4: The destination address is the first six bytes, with byte 0 in bits 7:0. A frame is accepted when this address equals `station_addr` or is all ones (broadcast).
- R5: A frame is multicast when bit 0 of its first byte is 1. A multicast frame is accepted when the all-multicast bit (bit 2) is set. Otherwise it is accepted when `hash_table[hash_idx]` is 1, with `hash_idx` sampled on the last beat.
- R6: With the promiscuous bit (bit 3) set, every frame passes the address check. The exception is a frame flagged by `own_tx`, sampled on the last beat, which passes only when the full-duplex bit (bit 5) is set.
- R7: With the abort-enable bit (bit 4) set, `collision` high in any cycle from the first beat through the last beat rejects the frame. When the full-duplex bit is set, `collision` has no effect.
- R8: A frame of more than MAX_LEN (2048) bytes is rejected. The same edge that raises its decision pulse sets bit 7 of the control register.
- R9: Bit 7 stays set until reset or a register write with bit 7 = 0. A write with bit 7 = 1 neither sets nor clears it. A hardware set in the same cycle as a clearing write wins.
- R10: `dec_len` is the frame byte count, which saturates at MAX_LEN+1. When the strip bit (bit 1) is set, the count is reduced by 4, with a floor of 0.
- R11: A frame shorter than MIN_LEN (14) bytes is rejected.
- R12: Register bits 0 to 5 are written from `ctl_wdata` when `ctl_we` is high and read back on `ctl_rdata` the next cycle. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts a byte |
| s_data | input | 8 | Received byte |
| s_last | input | 1 | Final byte of the frame |
| collision | input | 1 | Collision indication from the MAC |
| own_tx | input | 1 | Frame is the node's own transmission (sampled on last beat) |
| hash_idx | input | 6 | Hash index from external CRC (sampled on last beat) |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_table | input | 64 | Multicast hash table |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_len | output | 12 | Length to commit |

## Verification
The bench aims at several corner cases. A 2100-byte frame checks that the counter saturates. A design that wraps the counter would report a small length and accept the frame. A receive-enable bit cleared two bytes into a frame checks the sampling point. A design that samples too late would drop that frame's decision, and a design that samples too early would decide the next frame. Own-transmission frames are sent in promiscuous mode with and without full duplex. Collisions are raised with and without full duplex, to catch a design that ignores the duplex gating. Writes with bit 7 high and low check the sticky flag, which a plain register would lose or set on a write of 1.

// File: rtl/rff_pkg.sv
package rff_pkg;
  localparam int unsigned CTL_W = 8;
  localparam int unsigned ADDR_BYTES = 6;

  typedef struct packed {
    logic ovf;
    logic rsvd;
    logic full_dup;
    logic abort_en;
    logic promisc;
    logic all_mcast;
    logic strip_crc;
    logic rx_en;
  } rff_ctl_t;
endpackage

// File: rtl/rff_ctl_reg.sv
module rff_ctl_reg
  import rff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ovf_set,
  output rff_ctl_t         ctl
);
  rff_ctl_t nxt;

  always_comb begin
    nxt = ctl;
    if (we) begin
      nxt.rx_en     = wdata[0];
      nxt.strip_crc = wdata[1];
      nxt.all_mcast = wdata[2];
      nxt.promisc   = wdata[3];
      nxt.abort_en  = wdata[4];
      nxt.full_dup  = wdata[5];
      nxt.ovf       = ctl.ovf & wdata[7];
    end
    nxt.rsvd = 1'b0;
    if (ovf_set) nxt.ovf = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= nxt;
  end

  // R9: the flag only falls after a clearing write
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.ovf) |-> $past(we && !wdata[7]));
endmodule

// File: rtl/rff_len_track.sv
module rff_len_track #(
  parameter int unsigned MAX_LEN = 2048,
  parameter int unsigned LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] total
);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);

  always_comb total = (cnt == SAT) ? SAT : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (beat) cnt <= last ? '0 : total;
  end

  assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT);
endmodule

// File: rtl/rff_addr_match.sv
module rff_addr_match
  import rff_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic [LEN_W-1:0]        idx,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    is_mcast,
  output logic                    is_bcast,
  output logic                    is_station
);
  logic [ADDR_BYTES-1:0] byte_eq;
  logic [ADDR_BYTES-1:0] byte_ones;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    logic [7:0] da_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             da_q <= '0;
      else if (beat && idx == LEN_W'(g))      da_q <= data;
    end
    assign byte_eq[g]   = (da_q == station[8*g +: 8]);
    assign byte_ones[g] = &da_q;
    if (g == 0) begin : g_grp
      assign is_mcast = da_q[0];
    end
  end

  assign is_station = &byte_eq;
  assign is_bcast   = &byte_ones;
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rff_pkg::*;
#(
  parameter int unsigned MAX_LEN   = 2048,
  parameter int unsigned MIN_LEN   = 14,
  parameter int unsigned CRC_BYTES = 4,
  parameter int unsigned HASH_W    = 6,
  parameter int unsigned LEN_W     = $clog2(MAX_LEN + 2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_last,
  input  logic                    collision,
  input  logic                    own_tx,
  input  logic [HASH_W-1:0]       hash_idx,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [2**HASH_W-1:0]    hash_table,
  input  logic                    ctl_we,
  input  logic [CTL_W-1:0]        ctl_wdata,
  output logic [CTL_W-1:0]        ctl_rdata,
  output logic                    dec_valid,
  output logic                    dec_accept,
  output logic [LEN_W-1:0]        dec_len
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] CRC_L = LEN_W'(CRC_BYTES);

  rff_ctl_t         ctl;
  logic             beat, in_frame, taking, aborted;
  logic             take_now, coll_hit, abort_now, end_ev;
  logic             oversize, runt, addr_ok, ovf_set;
  logic             is_mcast, is_bcast, is_station;
  logic [LEN_W-1:0] cnt, total, len_out;

  assign s_ready   = !dec_valid;
  assign beat      = s_valid && s_ready;
  assign ctl_rdata = ctl;

  rff_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ovf_set(ovf_set), .ctl(ctl)
  );

  rff_len_track #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(s_last),
    .cnt(cnt), .total(total)
  );

  rff_addr_match #(.LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .idx(cnt), .data(s_data),
    .station(station_addr), .is_mcast(is_mcast), .is_bcast(is_bcast),
    .is_station(is_station)
  );

  always_comb begin
    take_now  = in_frame ? taking : ctl.rx_en;
    coll_hit  = collision && ctl.abort_en && !ctl.full_dup && (in_frame || beat);
    abort_now = aborted || coll_hit;
    end_ev    = beat && s_last && take_now;
    oversize  = total > MAX_L;
    runt      = total < MIN_L;
    addr_ok   = is_bcast
             || (!is_mcast && is_station)
             || (is_mcast && (ctl.all_mcast || hash_table[hash_idx]))
             || (ctl.promisc && (!own_tx || ctl.full_dup));
    ovf_set   = end_ev && oversize;
    if (ctl.strip_crc) len_out = (total >= CRC_L) ? total - CRC_L : '0;
    else               len_out = total;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      taking   <= 1'b0;
      aborted  <= 1'b0;
    end else if (beat && s_last) begin
      in_frame <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      if (beat) begin
        in_frame <= 1'b1;
        taking   <= take_now;
      end
      if (coll_hit) aborted <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_len    <= '0;
    end else begin
      dec_valid  <= end_ev;
      dec_accept <= end_ev && !abort_now && !oversize && !runt && addr_ok;
      if (end_ev) dec_len <= len_out;
    end
  end

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s_valid && s_ready && s_last));
  assert_accept_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  assert_no_long_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_len <= MAX_L);
  assert_ovf_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.ovf) |-> (dec_valid && !dec_accept));
endmodule

// File: tb/test_rx_frame_filter.sv
`timescale 1ns/1ps
module test_rx_frame_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, collision = 1'b0, own_tx = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic [5:0]  hash_idx = '0;
  logic [47:0] station_addr = 48'h665544332210;
  logic [63:0] hash_table = 64'hA5C3_0F96_3C5A_E718;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0, ctl_rdata;
  logic        dec_valid, dec_accept;
  logic [11:0] dec_len;

  int n_chk = 0, n_bad = 0;
  logic [7:0] cfg = '0;
  bit exp_flag = 0;

  always #5 clk = ~clk;

  rx_frame_filter i_rx_frame_filter (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .collision(collision), .own_tx(own_tx),
    .hash_idx(hash_idx), .station_addr(station_addr), .hash_table(hash_table),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_len(dec_len)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_acc(input logic [7:0] c, input int len, input logic [47:0] da,
                                   input bit own, input logic [5:0] h, input bit coll);
    bit mc = da[0];
    bit ok = (da == '1) || (!mc && da == station_addr) ||
             (mc && (c[2] || hash_table[h])) || (c[3] && (!own || c[5]));
    if (coll && c[4] && !c[5]) return 0;
    if (len > 2048 || len < 14) return 0;
    return ok;
  endfunction

  function automatic int model_len(input logic [7:0] c, input int len);
    int t = (len > 2048) ? 2049 : len;
    if (c[1]) return (t >= 4) ? t - 4 : 0;
    return t;
  endfunction

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    cfg = {2'b00, v[5:0]};
    if (!v[7]) exp_flag = 0;
    chk("R12 readback", ctl_rdata, {exp_flag, 1'b0, cfg[5:0]});
  endtask

  task automatic send_frame(input int len, input logic [47:0] da, input bit own,
                            input logic [5:0] h, input int coll_at, input bit mid_dis,
                            input bit gaps, input string req);
    bit taken = cfg[0];
    bit coll = (coll_at >= 0 && coll_at < len);
    logic [7:0] c0 = cfg;
    for (int i = 0; i < len; i++) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        s_valid = 1'b0; collision = 1'b0; ctl_we = 1'b0;
      end
      @(negedge clk);
      ctl_we    = 1'b0;
      s_valid   = 1'b1;
      s_data    = (i < 6) ? da[8*i +: 8] : 8'($urandom);
      s_last    = (i == len - 1);
      collision = (i == coll_at);
      own_tx    = own;
      hash_idx  = h;
      if (mid_dis && i == 2) begin
        ctl_we = 1'b1;
        ctl_wdata = {1'b1, 1'b0, cfg[5:1], 1'b0};
        cfg[0] = 1'b0;
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; collision = 1'b0; ctl_we = 1'b0;
    chk({req, " R2/R3 dec_valid"}, dec_valid, taken);
    if (taken) begin
      chk({req, " R2 s_ready low"}, s_ready, 1'b0);
      chk({req, " accept"}, dec_accept, model_acc(c0, len, da, own, h, coll));
      chk({req, " R10 len"}, dec_len, model_len(c0, len));
      if (len > 2048) exp_flag = 1;
    end
    chk({req, " R8/R9 flag"}, ctl_rdata[7], exp_flag);
    @(negedge clk);
    chk({req, " R2 pulse ends"}, dec_valid, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] mc_da;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 s_ready", s_ready, 1'b1);

    write_ctl(8'hFF);                     // R12: bit6 reads 0, bit7 write-1 ignored
    chk("R12 all ones", ctl_rdata, 8'h3F);

    write_ctl(8'h01);
    send_frame(64, station_addr, 0, 0, -1, 0, 0, "R4 station");
    send_frame(64, 48'h665544332220, 0, 0, -1, 0, 1, "R4 miss");
    send_frame(60, '1, 0, 0, -1, 0, 0, "R4 bcast");
    mc_da = 48'h0000_0000_0001;
    send_frame(40, mc_da, 0, 6'd3, -1, 0, 0, "R5 hash hit");
    send_frame(40, mc_da, 0, 6'd0, -1, 0, 0, "R5 hash miss");
    write_ctl(8'h05);
    send_frame(40, mc_da, 0, 6'd0, -1, 0, 0, "R5 all mcast");
    write_ctl(8'h09);
    send_frame(30, 48'h123456789ABC, 0, 0, -1, 0, 0, "R6 promisc");
    send_frame(30, 48'h123456789ABC, 1, 0, -1, 0, 0, "R6 own hd");
    write_ctl(8'h29);
    send_frame(30, 48'h123456789ABC, 1, 0, -1, 0, 0, "R6 own fd");
    write_ctl(8'h11);
    send_frame(50, station_addr, 0, 0, 20, 0, 0, "R7 abort");
    send_frame(50, station_addr, 0, 0, 0, 0, 0, "R7 abort first");
    write_ctl(8'h31);
    send_frame(50, station_addr, 0, 0, 20, 0, 0, "R7 fd ignore");
    write_ctl(8'h01);
    send_frame(13, station_addr, 0, 0, -1, 0, 0, "R11 runt");
    send_frame(14, station_addr, 0, 0, -1, 0, 0, "R11 min");
    send_frame(1, station_addr, 0, 0, -1, 0, 0, "R11 one byte");
    write_ctl(8'h03);
    send_frame(70, station_addr, 0, 0, -1, 0, 0, "R10 strip");
    send_frame(2048, station_addr, 0, 0, -1, 0, 0, "R8 max len");
    send_frame(2100, station_addr, 0, 0, -1, 0, 0, "R8 oversize");
    write_ctl(8'h81);                     // R9: write of 1 keeps flag
    write_ctl(8'h01);                     // R9: write of 0 clears
    write_ctl(8'h00);
    send_frame(30, station_addr, 0, 0, -1, 0, 0, "R3 disabled");
    write_ctl(8'h01);
    send_frame(30, station_addr, 0, 0, -1, 1, 0, "R3 mid disable");
    send_frame(30, station_addr, 0, 0, -1, 0, 0, "R3 after disable");

    for (int k = 0; k < 150; k++) begin
      logic [47:0] da;
      int sel = $urandom_range(0, 3);
      int len = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 13) : $urandom_range(14, 120);
      int ca = ($urandom_range(0, 4) == 0) ? $urandom_range(0, len - 1) : -1;
      logic [7:0] c = 8'($urandom) & 8'h3F;
      if ($urandom_range(0, 7) != 0) c[0] = 1'b1;
      if (k % 10 == 0) write_ctl({1'b1, 1'b0, c[5:0]});
      case (sel)
        0: da = station_addr;
        1: da = '1;
        2: da = {40'($urandom), 8'($urandom) | 8'h01};
        default: da = {16'($urandom), 32'($urandom)};
      endcase
      send_frame(len, da, 1'($urandom), 6'($urandom), ca, 0, 1, "R4-mix random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule